// File: doc/BRIEF.md
# Coherent Snapshot Real-Time Clock Register File

This block holds a BCD time-of-day and calendar. The host never reaches the running counters directly. A bank of eight transfer bytes sits between the host and the counters. At the start of every host transfer, the whole bank is refreshed from the counters in a single clock cycle. Every byte the host then reads, in any order and however slowly, comes from that one instant. Bytes the host writes into the bank stay there until the transfer ends. At that point the complete bank is loaded into the counters in one step.

A halt flag, bit 6 of the control byte at address 0x0C, is raised whenever the power-fail input is high. When the flag is raised, the counters' present value is latched into the bank as a power-down time-stamp. While the flag stays set, transfer starts no longer refresh the bank, so reads keep returning the time-stamp. If the host writes clock bytes before it clears the flag, the stale bank is committed over the running time, exactly as a plain transfer would commit it. Software must therefore clear the flag first. The 1 Hz tick comes from a prescaler that counts oscillator-enable pulses. The host side is an abstract transaction port with start, address, read and write strobes and stop, plus an address pointer that steps after every byte.

Top module: `rtc_snap_regfile`

## Requirements
- R1: After reset the counters hold second 00, minute 00, hour 00, weekday 01, date 01, month 01, year 00, with the fraction byte at 0. The halt flag is clear and registers 0x08 to 0x0C read 0.
- R2: With halt clear, a transfer start copies all counters and the fraction byte into the bank in the same cycle. Address 0x00 is the fraction byte, 0x01 seconds, 0x02 minutes, 0x03 hours, 0x04 weekday, 0x05 date, 0x06 month and 0x07 year, all BCD. A tick that arrives in the start cycle is applied before the copy.
- R3: Within a transfer, reads and writes of 0x00 to 0x07 touch only the bank. The counters keep running, but their new values are not seen until the next start.
- R4: A stop after at least one write to 0x00 to 0x07 loads bank bytes 0x01 to 0x07 into the counters together and restarts the prescaler at 0. A transfer with no such write leaves the counters and the prescaler untouched.
- R5: The start address loads the pointer, and any address above 0x0C loads 0x00. Each read or write strobe advances the pointer by one, and 0x0C is followed by 0x00.
- R6: While power-fail is high, the halt flag is set from the next cycle on. In the cycle the flag is first raised, the bank latches the counters and the fraction as a time-stamp.
- R7: While halt is set, transfer starts leave the bank unchanged, so reads return the time-stamp and the bytes written since. Register 0x0C reads with bit 6 = 1.
- R8: A clock-byte write committed while halt is set loads the stale bank, with the new bytes merged in, over the running counters.
- R9: Addresses 0x08 to 0x0C are read and written directly. Writing 0 to bit 6 of 0x0C clears halt, and the next start refreshes the bank again.
- R10: The prescaler advances once per cycle with oscillator-enable high. It wraps after PRESCALE pulses, and the wrap is the tick that advances the seconds.
- R11: BCD rollover runs as follows. Seconds and minutes go 59 to 00 and hours go 23 to 00. The weekday goes 7 to 1. The date passes the last day of the month to 01, using 28, 29 in years divisible by 4, 30 or 31 days. The month goes 12 to 01, and the year goes 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator period |
| pwr_fail | input | 1 | Power failing; raises halt |
| xfer_start | input | 1 | Begin a host transfer |
| xfer_addr | input | 8 | Start address for the pointer |
| wr_stb | input | 1 | Write wr_data at the pointer, then advance |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Consume rd_data, then advance |
| rd_data | output | 8 | Byte at the pointer |
| xfer_stop | input | 1 | End the transfer; commit if clock bytes were written |
| halt | output | 1 | Halt flag (bit 6 of 0x0C) |

## Verification
Random valid dates and times are committed, and a random number of whole seconds is then run. The results are compared with a calendar model. This separates correct carries from off-by-one month lengths and leap-year errors. Directed edge dates cover month end, Feb 28/29 and year 99. A tick forced into the start cycle shows whether the copy is taken before or after the increment. A tick during an open transfer shows whether reads come from the bank or from live counters. The power-fail sequence compares a read taken under halt, a commit made under halt, and a read taken after halt is cleared. Together they separate the time-stamp, the overwrite hazard and the return of refreshing.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

   localparam int unsigned CLK_BYTES = 8;
   localparam int unsigned CTRL_IDX  = 12;
   localparam int unsigned GP_BYTES  = CTRL_IDX - CLK_BYTES;
   localparam int unsigned HALT_POS  = 6;
   localparam int unsigned PTR_W     = $clog2(CTRL_IDX + 1);

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                      dow: 8'h01, hour: 8'h00, min: 8'h00,
                                      sec: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   // tens digit odd when bit 4 set
   function automatic logic is_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic rtc_time_t time_tick(input rtc_time_t t);
      rtc_time_t n;
      n = t;
      if (t.sec < 8'h59) n.sec = bcd_inc(t.sec);
      else begin
         n.sec = 8'h00;
         if (t.min < 8'h59) n.min = bcd_inc(t.min);
         else begin
            n.min = 8'h00;
            if (t.hour < 8'h23) n.hour = bcd_inc(t.hour);
            else begin
               n.hour = 8'h00;
               n.dow  = (t.dow >= 8'h07) ? 8'h01 : bcd_inc(t.dow);
               if (t.date < last_day(t.mon, t.year)) n.date = bcd_inc(t.date);
               else begin
                  n.date = 8'h01;
                  if (t.mon < 8'h12) n.mon = bcd_inc(t.mon);
                  else begin
                     n.mon  = 8'h01;
                     n.year = (t.year >= 8'h99) ? 8'h00 : bcd_inc(t.year);
                  end
               end
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic       restart,
   output logic       tick,
   output logic [7:0] frac_nxt
);
   localparam int unsigned CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_run;

   assign tick    = osc_en && (cnt_q == LAST);
   assign cnt_run = !osc_en ? cnt_q : (tick ? '0 : cnt_q + CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cnt_q <= '0;
      else                   cnt_q <= cnt_run;
   end

   // fraction byte: top eight bits of the count, or the whole count if narrower
   generate
      if (CW >= 8) begin : g_wide
         assign frac_nxt = cnt_run[CW-1 -: 8];
      end else begin : g_narrow
         assign frac_nxt = {{(8-CW){1'b0}}, cnt_run};
      end
   endgenerate
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
   import rtc_snap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cur,
   output rtc_time_t nxt
);
   assign nxt = tick ? time_tick(cur) : cur;

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= TIME_RST;
      else if (load) cur <= load_val;
      else           cur <= nxt;
   end
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
   import rtc_snap_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwr_fail,
   input  logic                     xfer_start,
   input  logic [7:0]               xfer_addr,
   input  logic                     wr_stb,
   input  logic [7:0]               wr_data,
   input  logic                     rd_stb,
   input  logic                     xfer_stop,
   input  rtc_time_t                snap_time,
   input  logic [7:0]               snap_frac,
   output logic [7:0]               rd_data,
   output logic                     halt,
   output logic                     commit,
   output rtc_time_t                commit_time,
   output logic [8*CLK_BYTES-1:0]   bank_flat,
   output logic [PTR_W-1:0]         ptr_o
);
   localparam int unsigned BW  = $clog2(CLK_BYTES);
   localparam int unsigned GW  = (GP_BYTES > 1) ? $clog2(GP_BYTES) : 1;
   localparam logic [PTR_W-1:0] PCTRL = PTR_W'(CTRL_IDX);
   localparam logic [8*CLK_BYTES-1:0] BANK_RST = {TIME_RST, 8'h00};

   logic [PTR_W-1:0] ptr_q;
   logic             halt_q, dirty_q;
   logic [7:0]       ctrl_q;
   logic [7:0]       gp_q [GP_BYTES];
   logic [8*CLK_BYTES-1:0] snap_vec;
   logic             access, wr_ok, refresh;

   assign access   = (wr_stb || rd_stb) && !xfer_start && !xfer_stop;
   assign wr_ok    = wr_stb && !xfer_start && !xfer_stop;
   assign refresh  = !halt_q && (xfer_start || pwr_fail);
   assign snap_vec = {snap_time, snap_frac};

   generate
      for (genvar gi = 0; gi < CLK_BYTES; gi++) begin : g_bank
         always_ff @(posedge clk) begin
            if (!rst_n)
               bank_flat[gi*8 +: 8] <= BANK_RST[gi*8 +: 8];
            else if (refresh)
               bank_flat[gi*8 +: 8] <= snap_vec[gi*8 +: 8];
            else if (wr_ok && ptr_q == PTR_W'(gi))
               bank_flat[gi*8 +: 8] <= wr_data;
         end
      end
      for (genvar gj = 0; gj < GP_BYTES; gj++) begin : g_gp
         always_ff @(posedge clk) begin
            if (!rst_n)                                   gp_q[gj] <= 8'h00;
            else if (wr_ok && ptr_q == PTR_W'(CLK_BYTES + gj)) gp_q[gj] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         halt_q  <= 1'b0;
         dirty_q <= 1'b0;
         ctrl_q  <= 8'h00;
      end else begin
         if (xfer_start)
            ptr_q <= (xfer_addr > 8'(CTRL_IDX)) ? '0 : xfer_addr[PTR_W-1:0];
         else if (access)
            ptr_q <= (ptr_q >= PCTRL) ? '0 : ptr_q + PTR_W'(1);

         if (xfer_start || xfer_stop)
            dirty_q <= 1'b0;
         else if (wr_ok && ptr_q < PTR_W'(CLK_BYTES))
            dirty_q <= 1'b1;

         if (wr_ok && ptr_q == PCTRL)
            ctrl_q <= wr_data & ~(8'h01 << HALT_POS);

         if (pwr_fail)
            halt_q <= 1'b1;
         else if (wr_ok && ptr_q == PCTRL)
            halt_q <= wr_data[HALT_POS];
      end
   end

   always_comb begin
      if (ptr_q < PTR_W'(CLK_BYTES))
         rd_data = bank_flat[ptr_q[BW-1:0]*8 +: 8];
      else if (ptr_q < PCTRL)
         rd_data = gp_q[ptr_q[GW-1:0]];
      else
         rd_data = ctrl_q | (8'(halt_q) << HALT_POS);
   end

   assign commit      = xfer_stop && dirty_q && !xfer_start;
   assign commit_time = bank_flat[8*CLK_BYTES-1:8];
   assign halt        = halt_q;
   assign ptr_o       = ptr_q;
endmodule

// File: rtl/rtc_snap_regfile.sv
module rtc_snap_regfile
   import rtc_snap_pkg::*;
#(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic       pwr_fail,
   input  logic       xfer_start,
   input  logic [7:0] xfer_addr,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   input  logic       rd_stb,
   output logic [7:0] rd_data,
   input  logic       xfer_stop,
   output logic       halt
);
   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
   endgenerate

   logic      tick, commit_w;
   logic [7:0] frac_nxt;
   rtc_time_t cnt_cur, cnt_nxt, commit_time;
   logic [8*CLK_BYTES-1:0] dbg_bank;
   logic [PTR_W-1:0]       dbg_ptr;

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .restart(commit_w),
      .tick(tick), .frac_nxt(frac_nxt)
   );

   rtc_counters u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(commit_w),
      .load_val(commit_time), .cur(cnt_cur), .nxt(cnt_nxt)
   );

   rtc_host_port u_port (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
      .xfer_start(xfer_start), .xfer_addr(xfer_addr),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
      .xfer_stop(xfer_stop), .snap_time(cnt_nxt), .snap_frac(frac_nxt),
      .rd_data(rd_data), .halt(halt), .commit(commit_w),
      .commit_time(commit_time), .bank_flat(dbg_bank), .ptr_o(dbg_ptr)
   );
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pwr_fail,
   input logic        xfer_start,
   input logic        xfer_stop,
   input logic        wr_stb,
   input logic        rd_stb,
   input logic        halt,
   input logic [3:0]  ptr,
   input logic [63:0] bank,
   input logic [55:0] cur,
   input logic        commit
);
   // R6
   halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> halt);

   // R5
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == 4'd12 && (rd_stb || wr_stb) && !xfer_start && !xfer_stop) |=> ptr == 4'd0);

   // R5
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= 4'd12);

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && xfer_start) |=> $stable(bank));

   // R3
   bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_start && !wr_stb && !pwr_fail) |=> $stable(bank));

   // R4
   commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> cur == $past(bank[63:8]));
endmodule

bind rtc_snap_regfile rtc_snap_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .xfer_start(xfer_start),
   .xfer_stop(xfer_stop), .wr_stb(wr_stb), .rd_stb(rd_stb), .halt(halt),
   .ptr(dbg_ptr), .bank(dbg_bank), .cur(cnt_cur), .commit(commit_w)
);

// File: tb/sim_rtc_snap_regfile.sv
module sim_rtc_snap_regfile;
   localparam int PS = 16;

   logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, pwr_fail = 1'b0;
   logic xfer_start = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, xfer_stop = 1'b0;
   logic [7:0] xfer_addr = 8'h00, wr_data = 8'h00;
   logic [7:0] rd_data;
   logic halt;

   int checks = 0, errors = 0;
   logic [55:0] mcur;
   int mpre;

   always #4 clk = ~clk;

   rtc_snap_regfile #(.PRESCALE(PS)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pwr_fail(pwr_fail),
      .xfer_start(xfer_start), .xfer_addr(xfer_addr), .wr_stb(wr_stb),
      .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
      .xfer_stop(xfer_stop), .halt(halt)
   );

   function automatic int b2i(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic logic [7:0] i2b(int v);
      return 8'(((v / 10) << 4) + (v % 10));
   endfunction
   function automatic int mdays(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction
   function automatic logic [55:0] pack_t(int s, int mi, int h, int dw, int d, int mo, int y);
      return {i2b(y), i2b(mo), i2b(d), i2b(dw), i2b(h), i2b(mi), i2b(s)};
   endfunction
   function automatic logic [55:0] m_tick(logic [55:0] t);
      int s, mi, h, dw, d, mo, y;
      s = b2i(t[7:0]); mi = b2i(t[15:8]); h = b2i(t[23:16]); dw = b2i(t[31:24]);
      d = b2i(t[39:32]); mo = b2i(t[47:40]); y = b2i(t[55:48]);
      s++;
      if (s == 60) begin
         s = 0; mi++;
         if (mi == 60) begin
            mi = 0; h++;
            if (h == 24) begin
               h = 0; dw = (dw == 7) ? 1 : dw + 1; d++;
               if (d > mdays(mo, y)) begin
                  d = 1; mo++;
                  if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
               end
            end
         end
      end
      return pack_t(s, mi, h, dw, d, mo, y);
   endfunction

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic t_start(logic [7:0] a);
      xfer_start = 1'b1; xfer_addr = a;
      @(negedge clk); xfer_start = 1'b0;
   endtask
   task automatic t_stop();
      xfer_stop = 1'b1;
      @(negedge clk); xfer_stop = 1'b0;
   endtask
   task automatic t_wr(logic [7:0] d);
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask
   task automatic t_rd(string tag, logic [7:0] exp);
      check(tag, rd_data, exp);
      rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask
   task automatic t_pulse(int n);
      for (int i = 0; i < n; i++) begin
         osc_en = 1'b1;
         @(negedge clk);
         if (mpre == PS - 1) begin mpre = 0; mcur = m_tick(mcur); end
         else mpre++;
      end
      osc_en = 1'b0;
   endtask
   task automatic read_all(string tag, logic [63:0] exp);
      t_start(8'h00);
      for (int i = 0; i < 8; i++) t_rd(tag, exp[i*8 +: 8]);
      t_stop();
   endtask
   task automatic write_time(logic [55:0] t);
      t_start(8'h00);
      t_wr(8'hA5);
      for (int i = 0; i < 7; i++) t_wr(t[i*8 +: 8]);
      t_stop();
      mcur = t; mpre = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [63:0] saved, stamp;
      void'($urandom(32'd91));
      mcur = pack_t(0, 0, 0, 1, 1, 1, 0); mpre = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 halt", {7'd0, halt}, 8'h00);
      read_all("R1 reset time", {mcur, 8'(mpre)});
      t_start(8'h08);
      for (int i = 0; i < 5; i++) t_rd("R1 noclock regs", 8'h00);
      t_stop();

      // R10 fraction count, R2 tick in the start cycle
      write_time(pack_t(10, 20, 5, 3, 14, 6, 21));
      t_pulse(PS - 1);
      read_all("R10 fraction", {mcur, 8'(mpre)});
      osc_en = 1'b1; xfer_start = 1'b1; xfer_addr = 8'h00;
      @(negedge clk);
      osc_en = 1'b0; xfer_start = 1'b0;
      mpre = 0; mcur = m_tick(mcur);
      for (int i = 0; i < 8; i++) t_rd("R2 tick at start", (i == 0) ? 8'h00 : mcur[(i-1)*8 +: 8]);
      t_stop();

      // R3 bank holds during an open transfer
      saved = {mcur, 8'(mpre)};
      t_start(8'h00);
      t_rd("R3 frac", saved[7:0]);
      t_rd("R3 sec", saved[15:8]);
      t_pulse(PS);
      for (int i = 2; i < 8; i++) t_rd("R3 stale bank", saved[i*8 +: 8]);
      t_stop();
      read_all("R3 next start", {mcur, 8'(mpre)});

      // R4 read-only and non-clock transfers do not commit
      t_pulse(5);
      read_all("R4 read only", {mcur, 8'(mpre)});
      t_start(8'h09); t_wr(8'h3C); t_stop();
      t_pulse(3);
      read_all("R4 noclock write", {mcur, 8'(mpre)});

      // R11 directed edges
      write_time(pack_t(59, 59, 23, 7, 28, 2, 23)); t_pulse(PS);
      read_all("R11 feb28 common", {mcur, 8'(mpre)});
      check("R11 march1", mcur[47:32], 16'h0301);
      write_time(pack_t(59, 59, 23, 2, 28, 2, 24)); t_pulse(PS);
      read_all("R11 feb28 leap", {mcur, 8'(mpre)});
      write_time(pack_t(59, 59, 23, 4, 30, 4, 50)); t_pulse(PS);
      read_all("R11 apr30", {mcur, 8'(mpre)});
      write_time(pack_t(59, 59, 23, 5, 31, 12, 99)); t_pulse(PS);
      read_all("R11 year99", {mcur, 8'(mpre)});
      check("R11 year wrap", mcur[55:48], 8'h00);

      // R11 R4 constrained random dates
      for (int n = 0; n < 20; n++) begin
         int mo, y;
         mo = $urandom_range(12, 1); y = $urandom_range(99, 0);
         write_time(pack_t($urandom_range(59, 0), $urandom_range(59, 0),
                           $urandom_range(23, 0), $urandom_range(7, 1),
                           $urandom_range(mdays(mo, y), 1), mo, y));
         t_pulse(PS * $urandom_range(3, 1) + $urandom_range(PS - 1, 0));
         read_all("R11 random", {mcur, 8'(mpre)});
      end

      // R5 pointer wrap and out-of-range start, R9 direct registers
      t_start(8'h08);
      for (int i = 0; i < 4; i++) t_wr(8'h11 * 8'(i + 1));
      t_stop();
      t_start(8'h0A);
      t_rd("R5 r9 gp 0A", 8'h33);
      t_rd("R5 r9 gp 0B", 8'h44);
      t_rd("R5 ctrl 0C", 8'h00);
      t_rd("R5 wrap to 00", 8'(mpre));
      t_rd("R5 then 01", mcur[7:0]);
      t_stop();
      t_start(8'h2F);
      t_rd("R5 high addr", 8'(mpre));
      t_stop();

      // R6 power fail sets halt and stamps the bank
      stamp = {mcur, 8'(mpre)};
      pwr_fail = 1'b1;
      @(negedge clk);
      pwr_fail = 1'b0;
      check("R6 halt set", {7'd0, halt}, 8'h01);
      t_pulse(2 * PS + 3);
      // R7 reads return the stamp
      read_all("R7 stamp", stamp);
      t_start(8'h0C);
      t_rd("R7 ctrl bit6", 8'h40);
      t_stop();

      // R8 clock write under halt overwrites running time
      t_start(8'h01); t_wr(8'h30); t_stop();
      mcur = {stamp[63:16], 8'h30}; mpre = 0;
      t_start(8'h0C); t_wr(8'h00); t_stop();
      check("R9 halt cleared", {7'd0, halt}, 8'h00);
      read_all("R8 stale commit", {mcur, 8'(mpre)});
      t_pulse(PS + 2);
      read_all("R9 refresh back", {mcur, 8'(mpre)});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule